// File: doc/BRIEF.md
# Two-Group Ratio Divider with Group Phase Offset

This block turns one input clock into ten clock-enable patterns, split into two groups of five. Each group owns one counter. A 4-bit code picks its division ratio from a fixed set that is not only powers of two. A phase value delays the group's pattern relative to the other group in whole steps. The step size is five input cycles when the ratio is a multiple of five and one input cycle otherwise. Each output has its own enable. An enable change is applied at a point where the group pattern is low, so no shortened pulse ever appears.

The ratio codes and phase values are plain register inputs. When any of them differs from the copy the block holds, the block starts a realignment. It captures the new setting and drives every output low for as many input cycles as the larger of the two ratios. It then restarts both counters in the same cycle, each from a start value set by its phase. The same realignment runs once after reset.

Top module: `grp_clk_divider`

## Requirements
- R1: Ratio codes 0 to 10 select ratios 1, 2, 4, 5, 8, 10, 16, 20, 32, 40 and 80 in that order, and codes 11 to 15 select ratio 1. Outside realignment each group pattern repeats every P input cycles, where P is the group's ratio.
- R2: With ratio 1 the group pattern is high on every cycle. With any other ratio P it is high during the first floor(P/2) cycles of each P-cycle period.
- R3: Outputs 0 to 4 follow group A, whose code is ratio_code_i[3:0] and whose phase is phase_step_i[6:0]. Outputs 5 to 9 follow group B, whose code is ratio_code_i[7:4] and whose phase is phase_step_i[13:7]. The two groups run their ratios independently.
- R4: The number of phase steps n is P/5 when P is a multiple of 5 and P otherwise. One step lasts 5 input cycles in the first case and 1 input cycle in the second. A phase value of n or more is reduced modulo n.
- R5: When a realignment ends, a group with an effective offset of d input cycles starts its counter at (P-d) mod P. Its first high cycle therefore comes d cycles after the first free-running cycle.
- R6: A realignment starts at any clock edge where the ratio codes or phase values differ from the captured setting. One also follows reset.
- R7: During a realignment all ten outputs are low for max(P_A, P_B) input cycles, and both group counters restart in the same cycle.
- R8: A disabled output is low. The enable of an output is captured only at edges where its group pattern is low, or at any edge when the group ratio is 1.
- R9: While reset is asserted, and after reset with all enables low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock that all patterns divide |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_code_i | input | 8 | Ratio codes, group A in bits 3:0, group B in bits 7:4 |
| phase_step_i | input | 14 | Phase values in steps, group A in bits 6:0, group B in bits 13:7 |
| out_en_i | input | 10 | Per-output enable, bit i for output i |
| clk_en_o | output | 10 | Divided clock-enable pattern per output |

## Verification
Several properties are checked on every cycle. Outputs stay low throughout a realignment. Each counter stays below its ratio. A ratio-1 group stays high. Both counters take their phase start values when a realignment ends. An output is never high while its group pattern is low. An output never changes while its group pattern stays high. Other behaviour can only be shown by the bench's scenarios with computed expectations. This covers the exact period and high time for every code, the arithmetic of the phase offset including values that wrap modulo the step count, the length of the hold as the larger of the two ratios, and the fact that a change to the phase alone triggers a realignment.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int unsigned DEF_N_GRP    = 2;
  localparam int unsigned DEF_GRP_SIZE = 5;
  localparam int unsigned DEF_CODE_W   = 4;
  localparam int unsigned DEF_PH_W     = 7;
  localparam int unsigned DEF_CNT_W    = 7;

  // ratio selection codes, ascending ratio order
  typedef enum logic [3:0] {
    RC_DIV1  = 4'd0,
    RC_DIV2  = 4'd1,
    RC_DIV4  = 4'd2,
    RC_DIV5  = 4'd3,
    RC_DIV8  = 4'd4,
    RC_DIV10 = 4'd5,
    RC_DIV16 = 4'd6,
    RC_DIV20 = 4'd7,
    RC_DIV32 = 4'd8,
    RC_DIV40 = 4'd9,
    RC_DIV80 = 4'd10
  } ratio_code_e;

endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cdiv_ratio_lut.sv
module cdiv_ratio_lut
  import cdiv_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned PH_W   = DEF_PH_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic [CNT_W-1:0]  ratio_o,
  output logic [CNT_W-1:0]  high_o,
  output logic [CNT_W-1:0]  preload_o
);

  logic [CNT_W-1:0] ratio_v;
  logic [CNT_W-1:0] steps_v;
  logic             by_five;
  logic [CNT_W-1:0] ph_ext;
  logic [CNT_W-1:0] ph_eff;
  logic [CNT_W-1:0] offset;

  // ratio, step count and step size per code; every step count is a power of two
  always_comb begin
    ratio_v = CNT_W'(1);
    steps_v = CNT_W'(1);
    by_five = 1'b0;
    case (code_i)
      CODE_W'(RC_DIV1):  begin ratio_v = CNT_W'(1);  steps_v = CNT_W'(1);  by_five = 1'b0; end
      CODE_W'(RC_DIV2):  begin ratio_v = CNT_W'(2);  steps_v = CNT_W'(2);  by_five = 1'b0; end
      CODE_W'(RC_DIV4):  begin ratio_v = CNT_W'(4);  steps_v = CNT_W'(4);  by_five = 1'b0; end
      CODE_W'(RC_DIV5):  begin ratio_v = CNT_W'(5);  steps_v = CNT_W'(1);  by_five = 1'b1; end
      CODE_W'(RC_DIV8):  begin ratio_v = CNT_W'(8);  steps_v = CNT_W'(8);  by_five = 1'b0; end
      CODE_W'(RC_DIV10): begin ratio_v = CNT_W'(10); steps_v = CNT_W'(2);  by_five = 1'b1; end
      CODE_W'(RC_DIV16): begin ratio_v = CNT_W'(16); steps_v = CNT_W'(16); by_five = 1'b0; end
      CODE_W'(RC_DIV20): begin ratio_v = CNT_W'(20); steps_v = CNT_W'(4);  by_five = 1'b1; end
      CODE_W'(RC_DIV32): begin ratio_v = CNT_W'(32); steps_v = CNT_W'(32); by_five = 1'b0; end
      CODE_W'(RC_DIV40): begin ratio_v = CNT_W'(40); steps_v = CNT_W'(8);  by_five = 1'b1; end
      CODE_W'(RC_DIV80): begin ratio_v = CNT_W'(80); steps_v = CNT_W'(16); by_five = 1'b1; end
      default:           begin ratio_v = CNT_W'(1);  steps_v = CNT_W'(1);  by_five = 1'b0; end
    endcase
  end

  // modulo by a power-of-two step count is a mask
  always_comb begin
    ph_ext = CNT_W'(phase_i);
    ph_eff = ph_ext & (steps_v - CNT_W'(1));
    offset = by_five ? ((ph_eff << 2) + ph_eff) : ph_eff;
  end

  assign ratio_o   = ratio_v;
  assign high_o    = (ratio_v == CNT_W'(1)) ? CNT_W'(1) : (ratio_v >> 1);
  assign preload_o = (offset == '0) ? '0 : (ratio_v - offset);

endmodule

// File: rtl/cdiv_group_ctr.sv
module cdiv_group_ctr #(
  parameter int unsigned CNT_W = cdiv_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [CNT_W-1:0] high_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hi_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_wrap;

  always_comb begin
    at_wrap = (cnt_q == (ratio_i - CNT_W'(1)));
    if (load_i) begin
      cnt_d = preload_i;
    end else if (at_wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign hi_o  = !load_i && (cnt_q < high_i);

endmodule

// File: rtl/cdiv_sync_ctl.sv
module cdiv_sync_ctl #(
  parameter int unsigned CFG_W = 22,
  parameter int unsigned CNT_W = cdiv_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [CNT_W-1:0] max_ratio_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             busy_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_we;
  logic             busy_q;
  logic             busy_d;
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] hold_d;
  logic             hold_last;

  always_comb begin
    cfg_we    = (cfg_i != cfg_q);
    hold_last = (hold_q == (max_ratio_i - CNT_W'(1)));
    cfg_d     = cfg_we ? cfg_i : cfg_q;
    busy_d    = busy_q;
    hold_d    = hold_q;
    if (cfg_we) begin
      busy_d = 1'b1;
      hold_d = '0;
    end else if (busy_q) begin
      if (hold_last) begin
        busy_d = 1'b0;
        hold_d = '0;
      end else begin
        hold_d = hold_q + CNT_W'(1);
      end
    end
  end

  // reset enters a one-cycle realignment with the all-zero setting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b1;
      hold_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      busy_q <= busy_d;
      hold_q <= hold_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/cdiv_out_gate.sv
module cdiv_out_gate #(
  parameter int unsigned N_OUT = cdiv_pkg::DEF_GRP_SIZE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grp_hi_i,
  input  logic             upd_ok_i,
  input  logic [N_OUT-1:0] en_i,
  output logic [N_OUT-1:0] out_o
);

  logic [N_OUT-1:0] en_q;
  logic [N_OUT-1:0] en_d;

  always_comb begin
    en_d = upd_ok_i ? en_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign out_o = {N_OUT{grp_hi_i}} & en_q;

endmodule

// File: rtl/grp_clk_divider.sv
module grp_clk_divider
  import cdiv_pkg::*;
#(
  parameter int unsigned N_GRP    = DEF_N_GRP,
  parameter int unsigned GRP_SIZE = DEF_GRP_SIZE,
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned PH_W     = DEF_PH_W,
  parameter int unsigned CNT_W    = DEF_CNT_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_GRP*CODE_W-1:0]     ratio_code_i,
  input  logic [N_GRP*PH_W-1:0]       phase_step_i,
  input  logic [N_GRP*GRP_SIZE-1:0]   out_en_i,
  output logic [N_GRP*GRP_SIZE-1:0]   clk_en_o
);

  localparam int unsigned N_OUT  = N_GRP * GRP_SIZE;
  localparam int unsigned CODE_T = N_GRP * CODE_W;
  localparam int unsigned CFG_W  = CODE_T + N_GRP * PH_W;

  logic                         rst_n_s;
  logic [CFG_W-1:0]             cfg_in;
  logic [CFG_W-1:0]             cfg_q;
  logic                         busy;
  logic [CNT_W-1:0]             max_ratio;
  logic [N_GRP-1:0][CNT_W-1:0]  ratio;
  logic [N_GRP-1:0][CNT_W-1:0]  high;
  logic [N_GRP-1:0][CNT_W-1:0]  preload;
  logic [N_GRP-1:0][CNT_W-1:0]  cnt;
  logic [N_GRP-1:0]             grp_hi;
  logic [N_GRP-1:0]             upd_ok;
  logic [N_OUT-1:0]             out_w;

  cdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign cfg_in = {phase_step_i, ratio_code_i};

  cdiv_sync_ctl #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .cfg_i       (cfg_in),
    .max_ratio_i (max_ratio),
    .cfg_o       (cfg_q),
    .busy_o      (busy)
  );

  // the hold lasts as long as the slower group's period
  always_comb begin
    max_ratio = CNT_W'(1);
    for (int g = 0; g < int'(N_GRP); g++) begin
      if (ratio[g] > max_ratio) begin
        max_ratio = ratio[g];
      end
    end
  end

  for (genvar g = 0; g < int'(N_GRP); g++) begin : g_grp
    cdiv_ratio_lut #(.CODE_W(CODE_W), .PH_W(PH_W), .CNT_W(CNT_W)) u_lut (
      .code_i    (cfg_q[g*CODE_W +: CODE_W]),
      .phase_i   (cfg_q[CODE_T + g*PH_W +: PH_W]),
      .ratio_o   (ratio[g]),
      .high_o    (high[g]),
      .preload_o (preload[g])
    );

    cdiv_group_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_s),
      .load_i    (busy),
      .preload_i (preload[g]),
      .ratio_i   (ratio[g]),
      .high_i    (high[g]),
      .cnt_o     (cnt[g]),
      .hi_o      (grp_hi[g])
    );

    // enables move only while the pattern is low, or anytime at ratio 1
    assign upd_ok[g] = !grp_hi[g] || (ratio[g] == CNT_W'(1));

    cdiv_out_gate #(.N_OUT(GRP_SIZE)) u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_s),
      .grp_hi_i (grp_hi[g]),
      .upd_ok_i (upd_ok[g]),
      .en_i     (out_en_i[g*GRP_SIZE +: GRP_SIZE]),
      .out_o    (out_w[g*GRP_SIZE +: GRP_SIZE])
    );
  end

  assign clk_en_o = out_w;

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int unsigned N_GRP    = 2,
  parameter int unsigned GRP_SIZE = 5,
  parameter int unsigned CNT_W    = 7
) (
  input logic                        clk_i,
  input logic                        rst_n,
  input logic                        busy,
  input logic [N_GRP-1:0][CNT_W-1:0] ratio,
  input logic [N_GRP-1:0][CNT_W-1:0] preload,
  input logic [N_GRP-1:0][CNT_W-1:0] cnt,
  input logic [N_GRP-1:0]            grp_hi,
  input logic [N_GRP*GRP_SIZE-1:0]   clk_en_o
);

  assert_low_in_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy |-> (clk_en_o == '0));

  for (genvar g = 0; g < int'(N_GRP); g++) begin : g_grp_chk
    assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
      $fell(busy) |-> (cnt[g] == preload[g]));

    assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
      !busy |-> (cnt[g] < ratio[g]));

    assert_unity_high_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!busy && (ratio[g] == CNT_W'(1))) |-> grp_hi[g]);

    for (genvar k = 0; k < int'(GRP_SIZE); k++) begin : g_out_chk
      assert_member_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
        clk_en_o[g*GRP_SIZE + k] |-> grp_hi[g]);

      assert_no_runt_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
        (grp_hi[g] && $past(grp_hi[g]) && (ratio[g] != CNT_W'(1)))
          |-> $stable(clk_en_o[g*GRP_SIZE + k]));
    end
  end

endmodule

bind grp_clk_divider cdiv_checker #(
  .N_GRP    (N_GRP),
  .GRP_SIZE (GRP_SIZE),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_s),
  .busy     (busy),
  .ratio    (ratio),
  .preload  (preload),
  .cnt      (cnt),
  .grp_hi   (grp_hi),
  .clk_en_o (clk_en_o)
);

// File: tb/tb_grp_clk_divider.sv
module tb_grp_clk_divider;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  ratio_code;
  logic [13:0] phase_step;
  logic [9:0]  en_in;
  logic [9:0]  clk_en;

  int checks = 0;
  int errors = 0;

  // bench model state
  int   m_code [2];
  int   m_ph   [2];
  int   n_code [2];
  int   n_ph   [2];
  bit   pending;
  int   busy_left;
  int   j_cnt;
  logic [9:0] en_eff;
  bit   hi_prev [2];

  grp_clk_divider dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ratio_code_i (ratio_code),
    .phase_step_i (phase_step),
    .out_en_i     (en_in),
    .clk_en_o     (clk_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int f_ratio(int code);
    case (code)
      0: return 1;   1: return 2;   2: return 4;   3: return 5;
      4: return 8;   5: return 10;  6: return 16;  7: return 20;
      8: return 32;  9: return 40;  10: return 80;
      default: return 1;
    endcase
  endfunction

  function automatic int f_start(int code, int ph);
    int p, n, unit, off;
    p    = f_ratio(code);
    n    = (p % 5 == 0) ? p / 5 : p;
    unit = (p % 5 == 0) ? 5 : 1;
    off  = (ph % n) * unit;
    return (off == 0) ? 0 : p - off;
  endfunction

  function automatic bit f_hi(int code, int ph, int j);
    int p, h;
    p = f_ratio(code);
    if (p == 1) return 1'b1;
    h = p / 2;
    return ((f_start(code, ph) + j) % p) < h;
  endfunction

  task automatic check_vec(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t clk_en=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic tick(string tag);
    bit         hi [2];
    logic [9:0] exp;
    @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      if (!hi_prev[i/5] || f_ratio(m_code[i/5]) == 1) en_eff[i] = en_in[i];
    end
    if (pending) begin
      m_code[0] = n_code[0]; m_code[1] = n_code[1];
      m_ph[0]   = n_ph[0];   m_ph[1]   = n_ph[1];
      busy_left = (f_ratio(n_code[0]) > f_ratio(n_code[1])) ? f_ratio(n_code[0]) : f_ratio(n_code[1]);
      pending   = 1'b0;
    end else if (busy_left > 0) begin
      busy_left--;
      j_cnt = 0;
    end else begin
      j_cnt++;
    end
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      hi[g] = (busy_left > 0) ? 1'b0 : f_hi(m_code[g], m_ph[g], j_cnt);
    end
    for (int i = 0; i < 10; i++) exp[i] = hi[i/5] & en_eff[i];
    check_vec((busy_left > 0) ? "R7" : tag, clk_en, exp);
    hi_prev[0] = hi[0];
    hi_prev[1] = hi[1];
  endtask

  task automatic drive_cfg(int ca, int cb, int pa, int pb);
    if (ca == m_code[0] && cb == m_code[1] && pa == m_ph[0] && pb == m_ph[1]) pb = pb ^ 1;
    n_code[0] = ca; n_code[1] = cb; n_ph[0] = pa; n_ph[1] = pb;
    ratio_code = {4'(cb), 4'(ca)};
    phase_step = {7'(pb), 7'(pa)};
    pending    = 1'b1;
  endtask

  task automatic run_cfg(int ca, int cb, int pa, int pb, string tag, int ncyc);
    drive_cfg(ca, cb, pa, pb);
    repeat (ncyc) tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    int ca, cb, mx;
    seed_v     = $urandom(32'd4711);
    rst_n      = 1'b0;
    ratio_code = '0;
    phase_step = '0;
    en_in      = '0;
    // R9: reset state
    repeat (4) begin
      @(negedge clk);
      check_vec("R9", clk_en, 10'b0);
    end
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check_vec("R9", clk_en, 10'b0);
    end
    m_code[0] = 0; m_code[1] = 0; m_ph[0] = 0; m_ph[1] = 0;
    pending = 1'b0; busy_left = 0; j_cnt = 0;
    en_eff = '0; hi_prev[0] = 1'b1; hi_prev[1] = 1'b1;

    en_in = '1;
    // R1 / R2: every legal code on each group
    for (int c = 0; c < 11; c++) begin
      run_cfg(c, 10 - c, 0, 0, "R1", 80 + 2 * f_ratio(c) + 4);
    end
    run_cfg(3, 5, 0, 0, "R2", 30);
    // R1: codes 11..15 act as ratio 1
    run_cfg(11, 15, 0, 0, "R1", 6);
    run_cfg(13, 12, 3, 9, "R1", 6);
    // R4 / R5: phase offsets, including modulo wrap
    run_cfg(4, 4, 3, 0, "R5", 30);
    run_cfg(9, 7, 13, 6, "R4", 130);
    run_cfg(10, 8, 21, 40, "R4", 200);
    run_cfg(3, 2, 7, 5, "R4", 20);
    // R6: change of phase alone restarts alignment
    run_cfg(6, 6, 0, 0, "R6", 40);
    run_cfg(6, 6, 0, 5, "R6", 40);
    // R8: drop enables while the pattern is high
    run_cfg(4, 4, 0, 0, "R8", 9);
    en_in = 10'b1101111110;
    repeat (12) tick("R8");
    en_in = '1;
    repeat (3) tick("R8");
    en_in = 10'b0110011001;
    repeat (20) tick("R8");
    // R3: independent groups with a mixed enable pattern
    en_in = 10'b1010110101;
    run_cfg(10, 0, 0, 0, "R3", 170);
    run_cfg(1, 9, 0, 3, "R3", 100);
    // random configurations and enable changes
    for (int it = 0; it < 40; it++) begin
      ca = $urandom % 16;
      cb = $urandom % 16;
      mx = (f_ratio(ca) > f_ratio(cb)) ? f_ratio(ca) : f_ratio(cb);
      run_cfg(ca, cb, $urandom % 128, $urandom % 128, "R5", mx + mx);
      en_in = 10'($urandom);
      repeat (mx + 10) tick("R8");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule